// File: doc/BRIEF.md
# Serial Port Buffer Event Flags

This block keeps the sticky event-flag word of a serial port, together with the two-entry transmit queue and two-entry receive queue whose activity raises many of those flags. The processor side pushes transmit words, pops received words, reads the flag word and clears flags with a bit mask. The serial side sends single-cycle pulses from the shift engines: a completed receive frame with its data and error qualifiers, address-frame detection, collision mismatch, an external select while acting as master, a master-driven frame start while acting as slave, a transmit-queue take, and the end of a shift-out.

A received frame is held for at least one cycle in a one-word receive holding stage. It moves into the receive queue as soon as the queue has room. Every flag is recorded whether or not it is enabled. An interrupt line combines the flags with an enable mask.

Top module: `sport_flag_core`

## Requirements
- R1: `flag_q` bits 12:0 hold, from bit 12 down to bit 0: collision fail, select-in-master, address frame, framing error, parity error, TX underflow, TX overflow, RX underflow, RX overflow, RX full, RX data valid, TX level, TX complete. Bits 31:13 always read 0.
- R2: After a synchronous active-low reset, `flag_q` equals 0x2, so only the TX level flag is set. Both queues and the holding stage are empty.
- R3: When `txl_at_empty`=1, TX level (bit 1) sets in a cycle where the TX queue goes from non-empty to empty. When `txl_at_empty`=0, it sets in a cycle where the queue goes from 2 entries to 1.
- R4: `tx_wr` to a full TX queue (2 entries) sets TX overflow (bit 6), even if a take happens in the same cycle. The word is dropped and the queued words keep their first-in, first-out order on `tx_head`.
- R5: `rx_rd` while the RX queue is empty sets RX underflow (bit 5) and changes no queue state.
- R6: `rx_frame` while the holding stage is occupied and cannot move into the queue in that cycle sets RX overflow (bit 4). The held word is replaced by the new one. Received words come out on `rx_rdata` in arrival order.
- R7: RX data valid (bit 2) sets when the RX queue goes from 0 entries to at least 1. RX full (bit 3) sets when the queue reaches 2 entries from fewer.
- R8: On `rx_frame`, `rx_ferr` sets framing error (bit 9) only while `rx_block`=0. `rx_perr` sets parity error (bit 8) only while `rx_block`=0 and `async_mode`=1.
- R9: `slave_start` while `sync_slave`=1 and the TX queue is empty sets TX underflow (bit 7).
- R10: `tx_done` sets TX complete (bit 0) when the TX queue is empty after that cycle's push and take.
- R11: Flags are sticky. A 1 in `flag_clr` clears the matching flag at the next edge, and a set event in the same cycle wins over the clear.
- R12: `irq` is 1 exactly when some flag is set whose bit in `irq_en` is 1. Flags are still recorded while their enable bit is 0.
- R13: `coll_fail`, `ss_master` and `addr_frame` pulses set bits 12, 11 and 10 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_wr | input | 1 | Processor push strobe for the TX queue |
| tx_wdata | input | DW | Word to push |
| rx_rd | input | 1 | Processor pop strobe for the RX queue |
| rx_rdata | output | DW | Oldest word in the RX queue |
| rx_avail | output | 1 | RX queue holds at least one word |
| flag_q | output | 32 | Flag word |
| flag_clr | input | 13 | Clear mask, one bit per flag |
| irq_en | input | 13 | Interrupt enable mask |
| irq | output | 1 | Interrupt request |
| txl_at_empty | input | 1 | TX level rule: 1 = empty, 0 = full to half |
| rx_block | input | 1 | Suppresses the receive error flags |
| async_mode | input | 1 | Asynchronous framing is in use |
| sync_slave | input | 1 | Synchronous slave operation |
| tx_take | input | 1 | Shift engine takes the TX head word |
| tx_head | output | DW | Oldest word in the TX queue |
| tx_avail | output | 1 | TX queue holds at least one word |
| tx_done | input | 1 | Shift-out finished, shift register empty |
| slave_start | input | 1 | Master started a frame (slave operation) |
| rx_frame | input | 1 | A frame was received |
| rx_sdata | input | DW | Data of the received frame |
| rx_perr | input | 1 | Received frame has a parity fault |
| rx_ferr | input | 1 | Received frame has a framing fault |
| addr_frame | input | 1 | Address frame detected |
| coll_fail | input | 1 | Collision check mismatch |
| ss_master | input | 1 | External select seen while master |

## Verification
Directed bursts fill the TX queue and then drain it, first under one level rule and then under the other, which separates the empty rule from the full-to-half rule. Back-to-back frames sent while the RX queue is not being read fill the queue, the holding stage and then overflow it, which separates RX full from overflow and shows which word is lost. A set pulse and a clear of the same bit in one cycle separates set priority from clear priority. Long random stretches with all strobes colliding, and with the mode inputs toggling, are compared every cycle against a queue-based model.

// File: rtl/sflg_pkg.sv
// Shared constants for the serial-port flag block: flag bit positions,
// flag count and reset value. Assumes a 13-flag word.
package sflg_pkg;
    localparam int NFLAG   = 13;
    localparam int F_TXC   = 0;
    localparam int F_TXL   = 1;
    localparam int F_RXDV  = 2;
    localparam int F_RXFUL = 3;
    localparam int F_RXOF  = 4;
    localparam int F_RXUF  = 5;
    localparam int F_TXOF  = 6;
    localparam int F_TXUF  = 7;
    localparam int F_PERR  = 8;
    localparam int F_FERR  = 9;
    localparam int F_ADDR  = 10;
    localparam int F_SSM   = 11;
    localparam int F_COLL  = 12;
    localparam logic [NFLAG-1:0] FLAG_RST = 13'h0002;
    typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/sflg_fifo.sv
// Small ring-buffer queue. A push is accepted when there is room or when a
// pop happens in the same cycle. A pop of an empty queue is ignored.
// Assumes DEPTH >= 2. Head data is combinational from storage.
module sflg_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         pop,
    input  logic [DW-1:0]                din,
    output logic [DW-1:0]                head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic [$clog2(DEPTH+1)-1:0]   count_nxt
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int PW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic          pop_ok, push_ok;

    // Accept decisions for this cycle
    always_comb begin
        pop_ok  = pop && (count != '0);
        push_ok = push && ((count != CW'(DEPTH)) || pop_ok);
        case ({push_ok, pop_ok})
            2'b10:   count_nxt = count + 1'b1;
            2'b01:   count_nxt = count - 1'b1;
            default: count_nxt = count;
        endcase
    end

    assign head = mem[rd_ptr];

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            count <= count_nxt;
            if (pop_ok)
                rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            if (push_ok)
                wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
        end
    end

    // Storage write, one slot per generated lane
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_ok && (wr_ptr == PW'(i)))
                mem[i] <= din;
        end
    end
endmodule

// File: rtl/sflg_tx.sv
// Transmit side: the TX queue plus the events it raises (level, overflow,
// underflow, complete). A push to a full queue is dropped even if a take
// occurs in the same cycle.
module sflg_tx #(
    parameter int DW    = 8,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          take,
    input  logic          done,
    input  logic          at_empty,
    input  logic          slave_start,
    input  logic          sync_slave,
    output logic [DW-1:0] head,
    output logic          avail,
    output logic          ev_level,
    output logic          ev_ovf,
    output logic          ev_udf,
    output logic          ev_cmpl
);
    localparam int CW = $clog2(DEPTH+1);

    logic [CW-1:0] cnt, cnt_nxt;
    logic          full;

    assign full = (cnt == CW'(DEPTH));

    sflg_fifo #(.DW(DW), .DEPTH(DEPTH)) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr && !full),
        .pop       (take),
        .din       (wdata),
        .head      (head),
        .count     (cnt),
        .count_nxt (cnt_nxt)
    );

    // Event detection from occupancy before and after this cycle
    always_comb begin
        avail   = (cnt != '0);
        ev_ovf  = wr && full;
        ev_udf  = slave_start && sync_slave && (cnt == '0);
        ev_cmpl = done && (cnt_nxt == '0);
        if (at_empty)
            ev_level = (cnt != '0) && (cnt_nxt == '0);
        else
            ev_level = full && (cnt_nxt == CW'(DEPTH-1));
    end
endmodule

// File: rtl/sflg_rx.sv
// Receive side: a one-word holding stage fed by the shift engine and the RX
// queue it drains into. A frame arriving while the held word cannot move
// overwrites it. Error qualifiers are only meaningful with the frame pulse.
module sflg_rx #(
    parameter int DW    = 8,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  logic          frame,
    input  logic [DW-1:0] sdata,
    input  logic          perr_in,
    input  logic          ferr_in,
    input  logic          blk,
    input  logic          async_mode,
    output logic [DW-1:0] rdata,
    output logic          avail,
    output logic          ev_udf,
    output logic          ev_ovf,
    output logic          ev_dv,
    output logic          ev_full,
    output logic          ev_perr,
    output logic          ev_ferr
);
    localparam int CW = $clog2(DEPTH+1);

    logic [CW-1:0] cnt, cnt_nxt;
    logic [DW-1:0] hold_d;
    logic          hold_v;
    logic          pop_ok, xfer;

    // Move the held word whenever the queue has or gains a free slot
    always_comb begin
        pop_ok = rd && (cnt != '0);
        xfer   = hold_v && ((cnt != CW'(DEPTH)) || pop_ok);
    end

    sflg_fifo #(.DW(DW), .DEPTH(DEPTH)) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (xfer),
        .pop       (rd),
        .din       (hold_d),
        .head      (rdata),
        .count     (cnt),
        .count_nxt (cnt_nxt)
    );

    // Holding stage update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v <= 1'b0;
            hold_d <= '0;
        end else if (frame) begin
            hold_v <= 1'b1;
            hold_d <= sdata;
        end else if (xfer) begin
            hold_v <= 1'b0;
        end
    end

    // Event detection
    always_comb begin
        avail   = (cnt != '0);
        ev_udf  = rd && (cnt == '0);
        ev_ovf  = frame && hold_v && !xfer;
        ev_dv   = (cnt == '0) && (cnt_nxt != '0);
        ev_full = (cnt != CW'(DEPTH)) && (cnt_nxt == CW'(DEPTH));
        ev_perr = frame && perr_in && !blk && async_mode;
        ev_ferr = frame && ferr_in && !blk;
    end
endmodule

// File: rtl/sflg_flagreg.sv
// Sticky flag register: each bit sets on its event and clears on its mask
// bit; a set in the same cycle as a clear wins. Reset value is per bit.
module sflg_flagreg #(
    parameter int               N   = 13,
    parameter logic [N-1:0]     RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // One sticky bit with set priority
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= RST[i];
            else if (set[i])
                q[i] <= 1'b1;
            else if (clr[i])
                q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/sport_flag_core.sv
// Serial-port event-flag core: TX and RX queues, the events they raise,
// the serial-side event pulses, and the sticky flag word with its
// interrupt. Assumes all serial-side inputs are single-cycle pulses that
// are already synchronous to clk.
module sport_flag_core
    import sflg_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 2,
    parameter int RW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_wr,
    input  logic [DW-1:0]    tx_wdata,
    input  logic             rx_rd,
    output logic [DW-1:0]    rx_rdata,
    output logic             rx_avail,
    output logic [RW-1:0]    flag_q,
    input  logic [NFLAG-1:0] flag_clr,
    input  logic [NFLAG-1:0] irq_en,
    output logic             irq,
    input  logic             txl_at_empty,
    input  logic             rx_block,
    input  logic             async_mode,
    input  logic             sync_slave,
    input  logic             tx_take,
    output logic [DW-1:0]    tx_head,
    output logic             tx_avail,
    input  logic             tx_done,
    input  logic             slave_start,
    input  logic             rx_frame,
    input  logic [DW-1:0]    rx_sdata,
    input  logic             rx_perr,
    input  logic             rx_ferr,
    input  logic             addr_frame,
    input  logic             coll_fail,
    input  logic             ss_master
);
    localparam int PADW = RW - NFLAG;

    flag_vec_t set_v, flags;
    logic t_lvl, t_ovf, t_udf, t_cmpl;
    logic r_udf, r_ovf, r_dv, r_full, r_perr, r_ferr;

    sflg_tx #(.DW(DW), .DEPTH(DEPTH)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (tx_wr),
        .wdata       (tx_wdata),
        .take        (tx_take),
        .done        (tx_done),
        .at_empty    (txl_at_empty),
        .slave_start (slave_start),
        .sync_slave  (sync_slave),
        .head        (tx_head),
        .avail       (tx_avail),
        .ev_level    (t_lvl),
        .ev_ovf      (t_ovf),
        .ev_udf      (t_udf),
        .ev_cmpl     (t_cmpl)
    );

    sflg_rx #(.DW(DW), .DEPTH(DEPTH)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd         (rx_rd),
        .frame      (rx_frame),
        .sdata      (rx_sdata),
        .perr_in    (rx_perr),
        .ferr_in    (rx_ferr),
        .blk        (rx_block),
        .async_mode (async_mode),
        .rdata      (rx_rdata),
        .avail      (rx_avail),
        .ev_udf     (r_udf),
        .ev_ovf     (r_ovf),
        .ev_dv      (r_dv),
        .ev_full    (r_full),
        .ev_perr    (r_perr),
        .ev_ferr    (r_ferr)
    );

    // Gather every event into its flag position
    always_comb begin
        set_v          = '0;
        set_v[F_TXC]   = t_cmpl;
        set_v[F_TXL]   = t_lvl;
        set_v[F_RXDV]  = r_dv;
        set_v[F_RXFUL] = r_full;
        set_v[F_RXOF]  = r_ovf;
        set_v[F_RXUF]  = r_udf;
        set_v[F_TXOF]  = t_ovf;
        set_v[F_TXUF]  = t_udf;
        set_v[F_PERR]  = r_perr;
        set_v[F_FERR]  = r_ferr;
        set_v[F_ADDR]  = addr_frame;
        set_v[F_SSM]   = ss_master;
        set_v[F_COLL]  = coll_fail;
    end

    sflg_flagreg #(.N(NFLAG), .RST(FLAG_RST)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_v),
        .clr   (flag_clr),
        .q     (flags)
    );

    assign flag_q = {{PADW{1'b0}}, flags};
    assign irq    = |(flags & irq_en);
endmodule

// File: rtl/sflg_checker.sv
// Property checker for sport_flag_core, attached by bind. Relates flag
// rises to the port stimulus of the previous cycle.
module sflg_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] flag_q,
    input logic [12:0] flag_clr,
    input logic [12:0] irq_en,
    input logic        irq,
    input logic        tx_wr,
    input logic        rx_rd,
    input logic        rx_frame,
    input logic        rx_block,
    input logic        async_mode,
    input logic        slave_start,
    input logic        sync_slave,
    input logic        tx_avail,
    input logic        coll_fail
);
    a_r2_reset_value: assert property (@(posedge clk)
        !rst_n |=> (flag_q == 32'h2));

    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q[31:13] == 19'd0);

    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(flag_q[12:0]) & ~flag_q[12:0] & ~$past(flag_clr)) == 13'd0));

    a_r4_txof_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[6]) |-> $past(tx_wr));

    a_r5_rxuf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[5]) |-> $past(rx_rd));

    a_r8_perr_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[8]) |-> $past(rx_frame && !rx_block && async_mode));

    a_r9_txuf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[7]) |-> $past(slave_start && sync_slave && !tx_avail));

    a_r13_coll_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[12]) |-> $past(coll_fail));

    a_r12_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 13'd0) |-> !irq);
endmodule

bind sport_flag_core sflg_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flag_q      (flag_q),
    .flag_clr    (flag_clr),
    .irq_en      (irq_en),
    .irq         (irq),
    .tx_wr       (tx_wr),
    .rx_rd       (rx_rd),
    .rx_frame    (rx_frame),
    .rx_block    (rx_block),
    .async_mode  (async_mode),
    .slave_start (slave_start),
    .sync_slave  (sync_slave),
    .tx_avail    (tx_avail),
    .coll_fail   (coll_fail)
);

// File: tb/sim_sport_flag_core.sv
// Bench for sport_flag_core: a queue-based reference model updated on
// every rising edge and compared with the outputs 2 ns later.
module sim_sport_flag_core;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_wr = 0, rx_rd = 0, txl_at_empty = 0, rx_block = 0, async_mode = 1;
    logic sync_slave = 0, tx_take = 0, tx_done = 0, slave_start = 0, rx_frame = 0;
    logic rx_perr = 0, rx_ferr = 0, addr_frame = 0, coll_fail = 0, ss_master = 0;
    logic [7:0]  tx_wdata = 0, rx_sdata = 0;
    logic [12:0] flag_clr = 0, irq_en = 0;
    logic [7:0]  rx_rdata, tx_head;
    logic        rx_avail, tx_avail, irq;
    logic [31:0] flag_q;

    int errors = 0, checks = 0, cyc = 0;

    always #5 clk = ~clk;

    sport_flag_core u0 (
        .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_avail(rx_avail),
        .flag_q(flag_q), .flag_clr(flag_clr), .irq_en(irq_en), .irq(irq),
        .txl_at_empty(txl_at_empty), .rx_block(rx_block), .async_mode(async_mode),
        .sync_slave(sync_slave), .tx_take(tx_take), .tx_head(tx_head),
        .tx_avail(tx_avail), .tx_done(tx_done), .slave_start(slave_start),
        .rx_frame(rx_frame), .rx_sdata(rx_sdata), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .addr_frame(addr_frame), .coll_fail(coll_fail),
        .ss_master(ss_master)
    );

    // Reference model state
    int txq[$];
    int rxq[$];
    bit hold_v;
    int hold_d;
    logic [12:0] mflags = 13'h2;

    function automatic string req_of(int b);
        case (b)
            0: return "R10";
            1: return "R3";
            2, 3: return "R7";
            4: return "R6";
            5: return "R5";
            6: return "R4";
            7: return "R9";
            8, 9: return "R8";
            default: return "R13";
        endcase
    endfunction

    // Model update on every rising edge
    always @(posedge clk) begin
        logic [12:0] s;
        int tc, tn, rc, rn;
        cyc++;
        if (!rst_n) begin
            txq.delete(); rxq.delete(); hold_v = 0; mflags = 13'h2;
        end else begin
            s = '0;
            tc = txq.size();
            if (tx_wr && tc == 2) s[6] = 1;
            if (tx_take && tc > 0) void'(txq.pop_front());
            if (tx_wr && tc < 2) txq.push_back(int'(tx_wdata));
            tn = txq.size();
            if (txl_at_empty ? (tc > 0 && tn == 0) : (tc == 2 && tn == 1)) s[1] = 1;
            if (slave_start && sync_slave && tc == 0) s[7] = 1;
            if (tx_done && tn == 0) s[0] = 1;
            rc = rxq.size();
            if (rx_rd && rc == 0) s[5] = 1;
            if (rx_rd && rc > 0) void'(rxq.pop_front());
            if (hold_v && rxq.size() < 2) begin rxq.push_back(hold_d); hold_v = 0; end
            if (rx_frame) begin
                if (hold_v) s[4] = 1;
                hold_d = int'(rx_sdata); hold_v = 1;
                if (rx_ferr && !rx_block) s[9] = 1;
                if (rx_perr && !rx_block && async_mode) s[8] = 1;
            end
            rn = rxq.size();
            if (rc == 0 && rn > 0) s[2] = 1;
            if (rc < 2 && rn == 2) s[3] = 1;
            if (addr_frame) s[10] = 1;
            if (ss_master)  s[11] = 1;
            if (coll_fail)  s[12] = 1;
            mflags = (mflags & ~flag_clr) | s;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare all outputs with the model, 2 ns after each edge
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            chk(flag_q[31:13] == 0, "R1", "upper bits", int'(flag_q[31:13]), 0);
            for (int b = 0; b < 13; b++)
                if (flag_q[b] !== mflags[b])
                    chk(0, req_of(b), $sformatf("flag bit %0d", b), int'(flag_q[b]), int'(mflags[b]));
            checks++;
            chk(irq === |(mflags & irq_en), "R12", "irq", int'(irq), int'(|(mflags & irq_en)));
            chk(tx_avail === (txq.size() > 0), "R4", "tx_avail", int'(tx_avail), int'(txq.size() > 0));
            if (txq.size() > 0)
                chk(int'(tx_head) == txq[0], "R4", "tx_head", int'(tx_head), txq[0]);
            chk(rx_avail === (rxq.size() > 0), "R5", "rx_avail", int'(rx_avail), int'(rxq.size() > 0));
            if (rxq.size() > 0)
                chk(int'(rx_rdata) == rxq[0], "R6", "rx_rdata", int'(rx_rdata), rxq[0]);
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            finish_run();
        end
    end

    task automatic idle();
        @(negedge clk);
        {tx_wr, rx_rd, tx_take, tx_done, slave_start, rx_frame, rx_perr, rx_ferr} = '0;
        {addr_frame, coll_fail, ss_master} = '0;
        flag_clr = '0;
    endtask

    task automatic push_tx(int d);
        idle(); tx_wr = 1; tx_wdata = 8'(d);
    endtask

    task automatic take_tx();
        idle(); tx_take = 1;
    endtask

    task automatic frame(int d, bit pe, bit fe);
        idle(); rx_frame = 1; rx_sdata = 8'(d); rx_perr = pe; rx_ferr = fe;
    endtask

    task automatic clear_all();
        idle(); flag_clr = '1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R2: reset value and empty queues
        chk(flag_q == 32'h2, "R2", "reset flag word", int'(flag_q), 2);
        chk(!tx_avail && !rx_avail, "R2", "queues empty", int'({tx_avail, rx_avail}), 0);
        // R12: flags recorded while masked, irq follows enable
        chk(irq == 0, "R12", "irq masked", int'(irq), 0);
        irq_en = 13'h2;
        #1 chk(irq == 1, "R12", "irq enabled", int'(irq), 1);
        irq_en = 0;
        // R3: full-to-half rule
        clear_all(); txl_at_empty = 0;
        push_tx(8'h11); push_tx(8'h22);
        // R4: overflow keeps queue contents
        push_tx(8'h33); take_tx(); take_tx(); idle(); idle();
        // R3: empty rule and R10 complete
        clear_all(); txl_at_empty = 1;
        push_tx(8'h44); take_tx(); idle(); tx_done = 1; idle();
        // R11: set and clear in the same cycle
        idle(); coll_fail = 1; flag_clr = 13'h1000; idle(); idle();
        clear_all(); idle();
        // R6/R7: RX fill, hold, overflow
        frame(8'hA1, 0, 0); frame(8'hA2, 0, 0); frame(8'hA3, 0, 0); frame(8'hA4, 0, 0);
        idle(); idle();
        // R5: drain then underflow
        repeat (4) begin idle(); rx_rd = 1; end
        idle(); idle();
        // R8: error gating
        rx_block = 1; frame(8'h01, 1, 1); idle();
        rx_block = 0; async_mode = 0; frame(8'h02, 1, 1); idle();
        async_mode = 1; frame(8'h03, 1, 1); idle();
        // R9 and R13
        sync_slave = 1; idle(); slave_start = 1; idle();
        idle(); addr_frame = 1; ss_master = 1; idle(); idle();
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            tx_wr = ($urandom % 4) == 0; tx_wdata = 8'($urandom);
            rx_rd = ($urandom % 4) == 0; tx_take = ($urandom % 4) == 0;
            tx_done = ($urandom % 6) == 0; slave_start = ($urandom % 8) == 0;
            rx_frame = ($urandom % 3) == 0; rx_sdata = 8'($urandom);
            rx_perr = ($urandom % 4) == 0; rx_ferr = ($urandom % 4) == 0;
            addr_frame = ($urandom % 16) == 0; coll_fail = ($urandom % 16) == 0;
            ss_master = ($urandom % 16) == 0;
            flag_clr = (($urandom % 3) == 0) ? 13'($urandom) : 13'd0;
            irq_en = 13'($urandom);
            if (($urandom % 50) == 0) txl_at_empty = ~txl_at_empty;
            if (($urandom % 50) == 0) rx_block = ~rx_block;
            if (($urandom % 50) == 0) async_mode = ~async_mode;
            if (($urandom % 50) == 0) sync_slave = ~sync_slave;
        end
        idle(); idle();
        finish_run();
    end
endmodule